// File: doc/BRIEF.md
# Bus-Quiet Gated Successive-Approximation Controller

This block sequences a 12-bit successive-approximation conversion. A start request opens a sample phase of fixed length. Twelve bit trials follow, most significant bit first. For each trial the block drives a trial code to an external DAC, waits a settle count, and then keeps or drops the trial bit according to an external comparator. When the last bit is decided, the result register loads and a one-clock done pulse marks the update.

A configuration bit turns on a quiet-wait mode. In this mode the end of the sample phase and every bit decision are postponed for as long as activity is seen on a nearby serial bus, so that each decision falls in a quiet period. A sustained burst of traffic therefore stretches the conversion without any limit. The raw activity line passes through a width filter first, so that pulses shorter than a configurable number of clocks never stall the sequence.

The quiet-wait mode is off after reset and is changed by a write strobe. The activity input is expected to be synchronous to `clk`.

Top module: `sar_quiet_ctrl`

## Requirements
- R1: After reset, `busy_o`, `sample_o`, `done_o`, `trial_code_o` and `result_o` are all zero, and quiet-wait is disabled until a write with `mode_quiet_i`=1 occurs.
- R2: A `start_i` seen in idle begins a sample phase of SAMPLE_CYC clocks. During this phase `sample_o` is 1 and `trial_code_o` is 0.
- R3: Trials run from bit RES_W-1 down to bit 0. The first trial code is only the MSB set (0x800 at 12 bits). A trial keeps its bit when `cmp_i`=1, which means the analog input is greater than or equal to the trial code. The final result therefore equals the code of the input.
- R4: `done_o` is high for exactly one clock, in the same cycle that `result_o` first shows the new value. With no stall, `done_o` appears SAMPLE_CYC + RES_W*SETTLE_CYC rising edges after the edge that captured `start_i` (56 by default).
- R5: A `start_i` asserted while a conversion is in progress has no effect. There is no restart and no extra done pulse.
- R6: With quiet-wait disabled, the conversion time is fixed regardless of `bus_act_i`.
- R7: A clock with `mode_wr_i`=1 loads `mode_quiet_i` as the quiet-wait enable. When it is enabled, the sample phase does not end while filtered activity is present.
- R8: When quiet-wait is enabled, a bit decision that falls due while filtered activity is present is held. `trial_code_o` stays unchanged until the filtered activity clears.
- R9: Filtered activity rises only after `bus_act_i` has been sampled high on FILT_CYC consecutive edges, and clears one clock after `bus_act_i` is sampled low. Shorter pulses never stall a conversion.
- R10: A stall has no upper bound. Activity held for thousands of clocks delays completion by the same amount, and the result is still correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Conversion request, accepted only in idle |
| mode_wr_i | input | 1 | Write strobe for the quiet-wait enable |
| mode_quiet_i | input | 1 | Quiet-wait enable value to write |
| bus_act_i | input | 1 | Raw serial-bus activity indication |
| cmp_i | input | 1 | Comparator output, 1 when input >= trial code |
| busy_o | output | 1 | Conversion in progress |
| sample_o | output | 1 | Sample phase active |
| done_o | output | 1 | One-clock result update pulse |
| trial_code_o | output | RES_W | Code driven to the DAC |
| result_o | output | RES_W | Last conversion result |

## Verification
The bench models the analog input as a code and derives `cmp_i` from it. It then checks the exact completion edge in several cases: quiet-wait off, quiet-wait on with no traffic, with sub-threshold glitch trains, with activity that covers the end of the sample phase, and with activity that arrives in the middle of the trials. There are four typical faults here. A filter that counts one edge too few would stall on the glitch trains and arrive late. A filter that releases one cycle late would add a clock to every stalled run. A gate that ignores the enable would stretch conversions while quiet-wait is off. A controller that re-arms on a start while busy would emit a second done pulse. The bench also covers the extreme values 0x000 and 0xFFF, a long stall, and the enable returning to off across a reset.

// File: rtl/sar_quiet_pkg.sv
package sar_quiet_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_TRIAL  = 2'd2
    } sar_state_e;

endpackage

// File: rtl/sar_act_filter.sv
// Width filter for the raw bus-activity line: the output rises once the
// input has been high on FILT_CYC consecutive edges, and falls on the first
// low sample.
module sar_act_filter #(
    parameter int unsigned FILT_CYC = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic act_o
);

    localparam int unsigned CW = $clog2(FILT_CYC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          act;
    } filt_t;

    filt_t filt_d, filt_q;

    always_comb begin
        filt_d = filt_q;
        if (raw_i) begin
            if (filt_q.cnt != CW'(FILT_CYC)) begin
                filt_d.cnt = filt_q.cnt + CW'(1);
            end
            filt_d.act = (filt_d.cnt == CW'(FILT_CYC));
        end else begin
            filt_d.cnt = '0;
            filt_d.act = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_q <= '0;
        end else begin
            filt_q <= filt_d;
        end
    end

    assign act_o = filt_q.act;

    AST_FILT_DROPS_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !raw_i |=> !act_o) else $error("filtered activity outlived raw input"); // R9

    AST_FILT_RISE_NEEDS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(act_o) |-> $past(raw_i)) else $error("filtered activity rose without raw input"); // R9

endmodule

// File: rtl/sar_phase_timer.sv
// Phase counter: cleared on entry to a phase, counts up to lim_i-1 and then
// sits at its terminal value until cleared, so a stalled phase stays due.
module sar_phase_timer #(
    parameter int unsigned MAX_CYC = 8,
    parameter int unsigned CW      = $clog2(MAX_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic [CW-1:0] lim_i,
    output logic          term_o
);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    assign term_o = (tmr_q.cnt == (lim_i - CW'(1)));

    always_comb begin
        tmr_d = tmr_q;
        if (clr_i) begin
            tmr_d.cnt = '0;
        end else if (!term_o) begin
            tmr_d.cnt = tmr_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    AST_TMR_PARKS_AT_TERM: assert property (@(posedge clk) disable iff (!rst_n)
        (term_o && !clr_i) |=> term_o) else $error("timer left its terminal count"); // R8

endmodule

// File: rtl/sar_bit_reg.sv
// Successive-approximation register: a one-hot pointer marks the bit on
// trial; a decision writes the comparator into it and raises the next one.
module sar_bit_reg #(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         load_i,
    input  logic         decide_i,
    input  logic         cmp_i,
    output logic [W-1:0] code_o,
    output logic         last_o
);

    typedef struct packed {
        logic [W-1:0] code;
        logic [W-1:0] ptr;
    } bits_t;

    bits_t        bits_d, bits_q;
    logic [W-1:0] code_nx;
    logic [W-1:0] raise_nx;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == W - 1) begin : g_top
            assign raise_nx[i] = 1'b0;
        end else begin : g_low
            assign raise_nx[i] = bits_q.ptr[i+1];
        end

        always_comb begin
            if (clr_i) begin
                code_nx[i] = 1'b0;
            end else if (load_i) begin
                code_nx[i] = (i == W - 1);
            end else if (decide_i) begin
                if (bits_q.ptr[i]) begin
                    code_nx[i] = cmp_i;
                end else if (raise_nx[i]) begin
                    code_nx[i] = 1'b1;
                end else begin
                    code_nx[i] = bits_q.code[i];
                end
            end else begin
                code_nx[i] = bits_q.code[i];
            end
        end
    end

    always_comb begin
        bits_d      = bits_q;
        bits_d.code = code_nx;
        if (clr_i) begin
            bits_d.ptr = '0;
        end else if (load_i) begin
            bits_d.ptr = {1'b1, {(W-1){1'b0}}};
        end else if (decide_i) begin
            bits_d.ptr = bits_q.ptr >> 1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else begin
            bits_q <= bits_d;
        end
    end

    assign code_o = bits_q.code;
    assign last_o = bits_q.ptr[0];

    AST_PTR_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bits_q.ptr)) else $error("trial pointer not one-hot"); // R3

    AST_LOAD_SETS_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !clr_i) |=> ($countones(code_o) == 1 && code_o[W-1])) else $error("first trial code wrong"); // R3

endmodule

// File: rtl/sar_quiet_ctrl.sv
module sar_quiet_ctrl
    import sar_quiet_pkg::*;
#(
    parameter int unsigned RES_W      = 12,
    parameter int unsigned SAMPLE_CYC = 8,
    parameter int unsigned SETTLE_CYC = 4,
    parameter int unsigned FILT_CYC   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             mode_wr_i,
    input  logic             mode_quiet_i,
    input  logic             bus_act_i,
    input  logic             cmp_i,
    output logic             busy_o,
    output logic             sample_o,
    output logic             done_o,
    output logic [RES_W-1:0] trial_code_o,
    output logic [RES_W-1:0] result_o
);

    localparam int unsigned TMR_MAX = (SAMPLE_CYC > SETTLE_CYC) ? SAMPLE_CYC : SETTLE_CYC;
    localparam int unsigned TMR_W   = $clog2(TMR_MAX + 1);

    typedef struct packed {
        sar_state_e       st;
        logic             quiet_en;
        logic             done;
        logic [RES_W-1:0] result;
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    logic             act_f;
    logic             stall;
    logic             tmr_clr;
    logic             tmr_term;
    logic [TMR_W-1:0] tmr_lim;
    logic             bits_clr;
    logic             bits_load;
    logic             bits_decide;
    logic             bits_last;
    logic [RES_W-1:0] code;

    sar_act_filter #(
        .FILT_CYC (FILT_CYC)
    ) i_filter (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i (bus_act_i),
        .act_o (act_f)
    );

    sar_phase_timer #(
        .MAX_CYC (TMR_MAX),
        .CW      (TMR_W)
    ) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (tmr_clr),
        .lim_i  (tmr_lim),
        .term_o (tmr_term)
    );

    sar_bit_reg #(
        .W (RES_W)
    ) i_bits (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (bits_clr),
        .load_i   (bits_load),
        .decide_i (bits_decide),
        .cmp_i    (cmp_i),
        .code_o   (code),
        .last_o   (bits_last)
    );

    assign stall   = ctl_q.quiet_en & act_f;
    assign tmr_lim = (ctl_q.st == ST_SAMPLE) ? TMR_W'(SAMPLE_CYC) : TMR_W'(SETTLE_CYC);

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.done  = 1'b0;
        tmr_clr     = 1'b0;
        bits_clr    = 1'b0;
        bits_load   = 1'b0;
        bits_decide = 1'b0;

        if (mode_wr_i) begin
            ctl_d.quiet_en = mode_quiet_i;
        end

        case (ctl_q.st)
            ST_IDLE: begin
                tmr_clr  = 1'b1;
                bits_clr = 1'b1;
                if (start_i) begin
                    ctl_d.st = ST_SAMPLE;
                end
            end
            ST_SAMPLE: begin
                if (tmr_term && !stall) begin
                    ctl_d.st  = ST_TRIAL;
                    tmr_clr   = 1'b1;
                    bits_load = 1'b1;
                end
            end
            ST_TRIAL: begin
                if (tmr_term && !stall) begin
                    tmr_clr = 1'b1;
                    if (bits_last) begin
                        ctl_d.result = {code[RES_W-1:1], cmp_i};
                        ctl_d.done   = 1'b1;
                        ctl_d.st     = ST_IDLE;
                        bits_clr     = 1'b1;
                    end else begin
                        bits_decide = 1'b1;
                    end
                end
            end
            default: begin
                ctl_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, quiet_en: 1'b0, done: 1'b0, result: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy_o       = (ctl_q.st != ST_IDLE);
    assign sample_o     = (ctl_q.st == ST_SAMPLE);
    assign done_o       = ctl_q.done;
    assign trial_code_o = code;
    assign result_o     = ctl_q.result;

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o) else $error("done longer than one clock"); // R4

    AST_SAMPLE_CODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |-> (trial_code_o == '0)) else $error("trial code during sample"); // R2

    AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_TRIAL && start_i) |=> !sample_o) else $error("start restarted a busy conversion"); // R5

    AST_SAMPLE_HELD_ON_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_o && ctl_q.quiet_en && act_f) |=> sample_o) else $error("sample ended during activity"); // R7

    AST_HOLD_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_TRIAL && ctl_q.quiet_en && act_f) |=> $stable(trial_code_o)) else $error("bit decided during activity"); // R8

    AST_FIXED_PACE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_TRIAL && !ctl_q.quiet_en && tmr_term) |=> !$stable(trial_code_o)) else $error("decision delayed while gating off"); // R6

endmodule

// File: tb/test_sar_quiet_ctrl.sv
module test_sar_quiet_ctrl;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned W   = 12;
    localparam int unsigned S   = 8;
    localparam int unsigned T   = 4;
    localparam int unsigned F   = 6;
    localparam int unsigned NOM = S + W * T;

    // pattern: 0 quiet, 1 glitch train, 2 held from before start until rel, 3 edges 31..40
    typedef struct packed {
        logic [11:0] vin;
        logic        en;
        logic [1:0]  pat;
        logic [15:0] rel;
        logic [15:0] lat;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{12'h000, 1'b0, 2'd0, 16'd0,  16'd56},
        '{12'hFFF, 1'b0, 2'd0, 16'd0,  16'd56},
        '{12'h800, 1'b1, 2'd0, 16'd0,  16'd56},
        '{12'h7FF, 1'b1, 2'd1, 16'd0,  16'd56},
        '{12'hA5A, 1'b0, 2'd2, 16'd20, 16'd56},
        '{12'h5A5, 1'b1, 2'd2, 16'd20, 16'd70},
        '{12'h123, 1'b0, 2'd3, 16'd0,  16'd56},
        '{12'hED4, 1'b1, 2'd3, 16'd0,  16'd58},
        '{12'h001, 1'b1, 2'd1, 16'd0,  16'd56}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         mode_wr = 1'b0;
    logic         mode_quiet = 1'b0;
    logic         bus_act = 1'b0;
    logic         cmp;
    logic         busy;
    logic         sample;
    logic         done;
    logic [W-1:0] trial_code;
    logic [W-1:0] result;
    logic [W-1:0] vin = '0;

    int unsigned n_tests = 0;
    int unsigned n_fail  = 0;

    always #4 clk = ~clk;

    assign cmp = (vin >= trial_code);

    sar_quiet_ctrl #(
        .RES_W      (W),
        .SAMPLE_CYC (S),
        .SETTLE_CYC (T),
        .FILT_CYC   (F)
    ) i_sar_quiet_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .mode_wr_i    (mode_wr),
        .mode_quiet_i (mode_quiet),
        .bus_act_i    (bus_act),
        .cmp_i        (cmp),
        .busy_o       (busy),
        .sample_o     (sample),
        .done_o       (done),
        .trial_code_o (trial_code),
        .result_o     (result)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic write_mode(input logic v);
        @(negedge clk);
        mode_wr    = 1'b1;
        mode_quiet = v;
        @(negedge clk);
        mode_wr    = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One conversion; counts rising edges after the edge that captured start.
    task automatic run_conv(input logic [W-1:0] v, input logic en, input logic [1:0] pat,
                            input int rel, input int exp_lat, input bit extra_start,
                            input string req);
        int  n       = 0;
        int  lat     = -1;
        int  sc      = 0;
        int  dones   = 0;
        int  exp_sc;
        logic [W-1:0] code_at_s = '0;
        logic [W-1:0] res = '0;
        if (pat == 2'd2) begin
            @(negedge clk);
            bus_act = 1'b1;
            repeat (F + 4) @(negedge clk);
        end
        @(negedge clk);
        vin   = v;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        while (lat < 0 && n < 6000) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            case (pat)
                2'd1: bus_act = ((n % (F + 3)) < (F - 1));
                2'd2: if (n == rel) bus_act = 1'b0;
                2'd3: begin
                    if (n == 30) bus_act = 1'b1;
                    if (n == 40) bus_act = 1'b0;
                end
                default: bus_act = 1'b0;
            endcase
            start = extra_start && (n == 20);
            if (sample) sc++;
            if (n == int'(S)) code_at_s = trial_code;
            if (done) begin
                lat = n;
                res = result;
                dones++;
            end
        end
        bus_act = 1'b0;
        start   = 1'b0;
        check(lat == exp_lat, {req, " latency"}, lat, exp_lat);
        check(res == v, {req, " R3 result"}, int'(res), int'(v));
        exp_sc = (pat == 2'd2 && en) ? (exp_lat - int'(W * T) - 1) : int'(S - 1);
        check(sc == exp_sc, {req, " R2 sample length"}, sc, exp_sc);
        if (!(pat == 2'd2 && en)) begin
            check(code_at_s == 12'h800, {req, " R3 first trial MSB"}, int'(code_at_s), 'h800);
        end
        @(negedge clk);
        check(!done, {req, " R4 done single clock"}, int'(done), 0);
        if (extra_start) begin
            for (int k = 0; k < int'(NOM) + 10; k++) begin
                @(negedge clk);
                if (done) dones++;
            end
            check(dones == 1, "R5 single done after busy start", dones, 1);
            check(!busy, "R5 no restart", int'(busy), 0);
        end
    endtask

    initial begin
        #(8ns * 200000);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!busy && !sample && !done, "R1 reset flags", {busy, sample, done}, 0);
        check(trial_code == '0, "R1 reset trial code", int'(trial_code), 0);
        check(result == '0, "R1 reset result", int'(result), 0);
        // R1 enable off after reset: sustained activity does not stall
        run_conv(12'h3C3, 1'b0, 2'd2, 20, NOM, 1'b0, "R1 enable off after reset");

        // Vector table: R3 R4 R6 R7 R8 R9
        foreach (VECS[i]) begin
            write_mode(VECS[i].en);
            run_conv(VECS[i].vin, VECS[i].en, VECS[i].pat, int'(VECS[i].rel),
                     int'(VECS[i].lat), 1'b0,
                     $sformatf("vec%0d R6 R7 R8 R9", i));
        end

        // R5 start while busy
        write_mode(1'b0);
        run_conv(12'h6B1, 1'b0, 2'd0, 0, NOM, 1'b1, "R5 busy start");

        // R10 long stall
        write_mode(1'b1);
        run_conv(12'h9E7, 1'b1, 2'd2, 3000, 3000 + 2 + int'(W * T), 1'b0, "R10 long stall");

        // R1 reset clears the enable again
        do_reset();
        @(negedge clk);
        check(result == '0, "R1 result cleared by reset", int'(result), 0);
        run_conv(12'h0F0, 1'b0, 2'd2, 20, NOM, 1'b0, "R1 enable cleared by reset");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule